// File: doc/BRIEF.md
# Write-Strobe Qualifier with Power-Up Lockout and Glitch Rejection

This block sits between a parallel memory bus and a flash program controller and decides which write strobes are allowed through. It takes the active-low chip-select, output-enable and write-enable lines, plus a digital supply-good flag from an external comparator. It passes the two strobes through a minimum-width filter and raises a write-allowed qualifier only when every condition for a safe program cycle holds at once.

All four inputs first pass through a configurable synchronizer. The qualifier stays low for a fixed number of clock cycles after the supply flag has been continuously good. Any dip of the flag restarts that count. A low strobe pulse reaches the filtered output only after it has been low for `MIN_W` consecutive samples. The filtered output returns high only after the input has been high for the same number of samples, so a brief high glitch inside a write does not split it in two. The program controller starts a cycle only while `wr_allow` is high.

Top module: `wgf_write_gate`

## Requirements
- R1: During and directly after reset, `cs_n_filt` and `we_n_filt` are 1 and `wr_allow` is 0.
- R2: When `supply_ok` is 0, `wr_allow` goes to 0 no later than `SYNC_STG+1` clock edges after the drop.
- R3: With the strobes low and output-enable high, `wr_allow` rises exactly `SYNC_STG+LOCK_CYC` clock edges after `supply_ok` rises, and not earlier.
- R4: A drop of `supply_ok` that lasts even a single cycle during the lockout restarts the full `LOCK_CYC` count from the moment it returns high.
- R5: While `oe_n_in` is 0, `wr_allow` is 0.
- R6: While the filtered chip-select is 1 or the filtered write-enable is 1, `wr_allow` is 0.
- R7: A low pulse of fewer than `MIN_W` cycles on `we_n_in` or `cs_n_in` leaves the corresponding filtered output at 1.
- R8: A low period of at least `MIN_W` cycles drives the filtered output to 0 exactly `SYNC_STG+MIN_W` edges after the input falls.
- R9: The filtered output returns to 1 exactly `SYNC_STG+MIN_W` edges after the input rises, and a high glitch shorter than `MIN_W` cycles during a low period leaves it at 0.
- R10: The strobe filters work regardless of supply state, and with supply held good a settled write condition gives `wr_allow` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-above-threshold flag from the comparator, 1 = good |
| cs_n_in | input | 1 | Bus chip-select, active low |
| oe_n_in | input | 1 | Bus output-enable, active low |
| we_n_in | input | 1 | Bus write-enable, active low |
| cs_n_filt | output | 1 | Width-filtered chip-select, active low |
| we_n_filt | output | 1 | Width-filtered write-enable, active low |
| wr_allow | output | 1 | 1 when a program cycle may start |

## Verification
The hardest case to reach is the lockout restart. The supply flag has to fall for one cycle part way through the count, and the bench must show that the qualifier then appears exactly a full lockout period after the flag comes back. The count must not continue from where it stopped. The bench first settles both strobes low with output-enable high so that the qualifier depends only on the lockout. It then raises the flag, drops it for one cycle fifteen cycles later, and samples the qualifier on the edge before and the edge at which it should rise. The exact-width pulse boundaries are reached the same way, with pulses one cycle shorter than the threshold and pulses exactly at the threshold.

// File: rtl/wgf_pkg.sv
package wgf_pkg;

   // Bundle of raw bus and supply controls, in the order the synchronizer carries them
   typedef struct packed {
      logic sup_ok;
      logic oe_n;
      logic cs_n;
      logic we_n;
   } bus_ctl_t;

   localparam int CTL_W = $bits(bus_ctl_t);

   // Idle levels: supply not yet trusted, all enables released
   localparam bus_ctl_t CTL_IDLE = '{sup_ok: 1'b0, oe_n: 1'b1, cs_n: 1'b1, we_n: 1'b1};

   localparam int MAX_SYNC = 4;

endpackage

// File: rtl/wgf_sync.sv
module wgf_sync #(
   parameter int W = 4,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 0 || STAGES > wgf_pkg::MAX_SYNC) begin : g_bad_stages
         $error("wgf_sync: STAGES out of range");
      end

      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
         end

         for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= RST_VAL;
               else        stg[i] <= stg[i-1];
            end
         end

         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/wgf_lockout.sv
module wgf_lockout #(
   parameter int LOCK_CYC = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_s,
   output logic ready
);

   localparam int CW = (LOCK_CYC > 1) ? $clog2(LOCK_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(LOCK_CYC - 1);

   generate
      if (LOCK_CYC < 1) begin : g_bad_lock
         $error("wgf_lockout: LOCK_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         ready <= 1'b0;
      end else if (!sup_s) begin
         cnt   <= '0;
         ready <= 1'b0;
      end else if (!ready) begin
         if (cnt == LAST) ready <= 1'b1;
         else             cnt   <= cnt + 1'b1;
      end
   end

   // R2: a bad supply sample always clears the ready flag on the next edge
   assert_drop_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sup_s |=> !ready);

   // R3: ready can only appear after a good supply sample
   assert_rise_needs_supply_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(sup_s));

   // R4: once reached, ready persists while the supply stays good
   assert_ready_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && sup_s) |=> ready);

endmodule

// File: rtl/wgf_pulse_filter.sv
module wgf_pulse_filter #(
   parameter int MIN_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din_n,
   output logic dout_n
);

   localparam int CW = (MIN_W > 1) ? $clog2(MIN_W) : 1;
   localparam logic [CW-1:0] LAST = CW'(MIN_W - 1);

   generate
      if (MIN_W < 1) begin : g_bad_width
         $error("wgf_pulse_filter: MIN_W must be at least 1");
      end
   endgenerate

   logic [CW-1:0] run;

   // A level change is accepted once the new level has been sampled MIN_W times in a row
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= '0;
         dout_n <= 1'b1;
      end else if (din_n == dout_n) begin
         run <= '0;
      end else if (run == LAST) begin
         run    <= '0;
         dout_n <= din_n;
      end else begin
         run <= run + 1'b1;
      end
   end

   // R8 / R9: the output only ever moves to the level the input just showed
   assert_follow_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout_n) |-> ($past(din_n) == dout_n));

   // R7: an input agreeing with the output never moves the output
   assert_agree_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (din_n == dout_n) |=> $stable(dout_n));

endmodule

// File: rtl/wgf_write_gate.sv
module wgf_write_gate #(
   parameter int LOCK_CYC = 500000,
   parameter int MIN_W    = 4,
   parameter int SYNC_STG = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic cs_n_in,
   input  logic oe_n_in,
   input  logic we_n_in,
   output logic cs_n_filt,
   output logic we_n_filt,
   output logic wr_allow
);
   import wgf_pkg::*;

   bus_ctl_t raw, syn;
   logic     lock_ready;

   assign raw = '{sup_ok: supply_ok, oe_n: oe_n_in, cs_n: cs_n_in, we_n: we_n_in};

   wgf_sync #(
      .W       (CTL_W),
      .STAGES  (SYNC_STG),
      .RST_VAL (CTL_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (syn)
   );

   wgf_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .sup_s (syn.sup_ok),
      .ready (lock_ready)
   );

   logic [1:0] strobe_s, strobe_f;
   assign strobe_s = {syn.cs_n, syn.we_n};

   generate
      for (genvar g = 0; g < 2; g++) begin : g_strobe
         wgf_pulse_filter #(.MIN_W(MIN_W)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .din_n  (strobe_s[g]),
            .dout_n (strobe_f[g])
         );
      end
   endgenerate

   assign cs_n_filt = strobe_f[1];
   assign we_n_filt = strobe_f[0];

   assign wr_allow = lock_ready & syn.oe_n & ~strobe_f[1] & ~strobe_f[0];

   // R6: a rising qualifier needs both filtered strobes to have been active already
   assert_allow_needs_strobes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_allow) |-> (!cs_n_filt && !we_n_filt && lock_ready));

endmodule

// File: tb/wgf_write_gate_test.sv
`timescale 1ns/1ps
module wgf_write_gate_test;

   localparam int LOCK = 20;
   localparam int MW   = 4;
   localparam int SYN  = 2;
   localparam int D_LK = SYN + LOCK;
   localparam int D_ST = SYN + MW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sup = 1'b0, cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic cs_f, we_f, allow;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wgf_write_gate #(.LOCK_CYC(LOCK), .MIN_W(MW), .SYNC_STG(SYN)) uut (
      .clk (clk), .rst_n (rst_n), .supply_ok (sup),
      .cs_n_in (cs_n), .oe_n_in (oe_n), .we_n_in (we_n),
      .cs_n_filt (cs_f), .we_n_filt (we_f), .wr_allow (allow)
   );

   // Vector: [15]sup [14]oe_n [13]cs_n [12]we_n [11:4]cycles [2]exp cs_f [1]exp we_f [0]exp allow
   localparam int NV = 8;
   localparam logic [15:0] VEC [NV] = '{
      {4'b1100, 8'd30, 1'b0, 3'b001},  // R10 write path open
      {4'b1000, 8'd10, 1'b0, 3'b000},  // R5 output-enable active
      {4'b1110, 8'd10, 1'b0, 3'b100},  // R6 chip-select released
      {4'b1101, 8'd10, 1'b0, 3'b010},  // R6 write-enable released
      {4'b1100, 8'd10, 1'b0, 3'b001},  // R10 back to open
      {4'b0100, 8'd10, 1'b0, 3'b000},  // R2 supply lost
      {4'b1111, 8'd30, 1'b0, 3'b110},  // R3 relocked, idle bus
      {4'b1100, 8'd10, 1'b0, 3'b001}   // R3 write after relock
   };

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drive(input logic s, input logic o, input logic c, input logic w);
      sup = s; oe_n = o; cs_n = c; we_n = w;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk("R1 cs_f in reset", cs_f, 1'b1);
      chk("R1 we_f in reset", we_f, 1'b1);
      chk("R1 allow in reset", allow, 1'b0);
      rst_n = 1'b1;
      edges(1);
      chk("R1 allow after reset", allow, 1'b0);

      // Power up and settle
      drive(1, 1, 1, 1);
      edges(40);

      foreach (VEC[v]) begin
         drive(VEC[v][15], VEC[v][14], VEC[v][13], VEC[v][12]);
         edges(int'(VEC[v][11:4]));
         chk($sformatf("vec%0d cs_f", v), cs_f, VEC[v][2]);
         chk($sformatf("vec%0d we_f", v), we_f, VEC[v][1]);
         chk($sformatf("vec%0d allow", v), allow, VEC[v][0]);
      end

      // R2: drop from locked state, qualifier falls within SYN+1 edges
      drive(0, 1, 0, 0);
      edges(SYN);
      chk("R2 allow before clear", allow, 1'b1);
      edges(1);
      chk("R2 allow cleared", allow, 1'b0);
      edges(10);

      // R3: exact lockout length
      sup = 1'b1;
      edges(D_LK - 1);
      chk("R3 allow one edge early", allow, 1'b0);
      edges(1);
      chk("R3 allow at lockout end", allow, 1'b1);

      // R4: one-cycle dip restarts the count
      sup = 1'b0;
      edges(10);
      sup = 1'b1;
      edges(15);
      sup = 1'b0;
      edges(1);
      sup = 1'b1;
      edges(D_LK - 1);
      chk("R4 allow one edge before restarted end", allow, 1'b0);
      edges(1);
      chk("R4 allow at restarted end", allow, 1'b1);

      // R7: short low pulses on each strobe
      drive(1, 1, 1, 1);
      edges(12);
      we_n = 1'b0;
      edges(MW - 1);
      we_n = 1'b1;
      begin
         bit seen_low = 1'b0;
         for (int i = 0; i < 12; i++) begin
            edges(1);
            if (we_f !== 1'b1) seen_low = 1'b1;
         end
         chk("R7 short we pulse rejected", seen_low, 1'b0);
      end
      cs_n = 1'b0;
      edges(MW - 1);
      cs_n = 1'b1;
      begin
         bit seen_low = 1'b0;
         for (int i = 0; i < 12; i++) begin
            edges(1);
            if (cs_f !== 1'b1) seen_low = 1'b1;
         end
         chk("R7 short cs pulse rejected", seen_low, 1'b0);
      end

      // R8 / R9: pulse of exactly MW cycles
      we_n = 1'b0;
      edges(D_ST - 1);
      chk("R8 we_f one edge early", we_f, 1'b1);
      edges(1);
      chk("R8 we_f fell", we_f, 1'b0);
      we_n = 1'b1;
      edges(D_ST - 1);
      chk("R9 we_f release one edge early", we_f, 1'b0);
      edges(1);
      chk("R9 we_f released", we_f, 1'b1);

      // R9: short high glitch inside a long low
      cs_n = 1'b0;
      edges(12);
      cs_n = 1'b1;
      edges(MW - 1);
      cs_n = 1'b0;
      begin
         bit seen_high = 1'b0;
         for (int i = 0; i < 12; i++) begin
            edges(1);
            if (cs_f !== 1'b0) seen_high = 1'b1;
         end
         chk("R9 high glitch ignored", seen_high, 1'b0);
      end

      // R10: filters act with the supply absent, qualifier stays low
      drive(0, 1, 1, 1);
      edges(12);
      we_n = 1'b0;
      edges(D_ST);
      chk("R10 we_f filtered with supply low", we_f, 1'b0);
      chk("R2 allow low with supply low", allow, 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule